// File: doc/BRIEF.md
# Serial Audio Frame Transmitter

This block serialises parallel audio sample words onto one data line. It drives the frame sync and the bit clock that go with that line. One frame engine handles four sync styles. It supports programmable clock and sync polarity, MSB-first or LSB-first order, a word width from 8 to 32 bits, a frame of one to eight word slots, and a per-slot mask. Samples arrive over a valid/ready word interface and are taken only at the start of an unmasked slot.

The bit clock is derived from the system clock by a programmable even divider and runs only while the transmitter is active. All configuration inputs are static: software sets them while the block is idle and then raises the enable. When the enable is lowered, the transmitter finishes the frame it is sending before it goes idle. The active output shows this trailing period.

Top module: `audio_frame_tx`

## Requirements
- R1: Format code 0 (two-channel standard mode). Frame sync is active low for one full word. It goes active one bit early, during the final bit of the preceding frame, and only if another frame follows.
- R2: Format code 1 (left-aligned mode). Frame sync is active high for exactly the bits of slot 0, starting with the frame's first data bit.
- R3: Format code 2 (early pulse mode). Frame sync is a one-bit active-high pulse during the final bit of the preceding frame, issued only if another frame follows. The word-width setting does not stretch it.
- R4: Format code 3 (late pulse mode). Frame sync is a one-bit active-high pulse that coincides with the first data bit of the frame.
- R5: `cfgBclkInv` and `cfgFsInv` each invert their pin by XOR on top of the format's own polarity. Without inversion, data changes on the falling bit-clock edge and is stable at the rising edge.
- R6: With `cfgLsbFirst`=0, each word is sent starting at bit index word length-1 and ending at index 0. With `cfgLsbFirst`=1, it is sent starting at index 0.
- R7: One bit period lasts 2×(`cfgDiv`+1) system clock cycles, so the clock ratio is always even.
- R8: A frame is `cfgChans` slots of `cfgWordLen` bits. Word lengths run from 8 to 32. The first frame after enabling is preceded by one lead bit with the data line low.
- R9: A slot whose bit in `cfgSlotMask` is 1 sends all-zero data and takes no word. Every unmasked slot takes exactly one word through a valid/ready transfer at its first bit.
- R10: If no sample is valid when an unmasked slot starts, that slot sends zeros and no word is taken.
- R11: The enable is sampled as the last bit of each frame begins. If it is low, the block stops after that bit. `txActive` stays high until then, so the block always sends a whole number of frames.
- R12: While idle, the bit clock rests at its inactive level (`cfgBclkInv`), frame sync rests at its inactive level, and the data line is low. This is also the state after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txEnable | input | 1 | Transmit request |
| cfgFormat | input | 2 | Sync style: 0 standard, 1 left-aligned, 2 early pulse, 3 late pulse |
| cfgBclkInv | input | 1 | Invert bit clock |
| cfgFsInv | input | 1 | Invert frame sync |
| cfgLsbFirst | input | 1 | Send bit 0 first |
| cfgWordLen | input | 6 | Bits per word, 8 to 32 |
| cfgChans | input | 4 | Slots per frame, 1 to 8 |
| cfgSlotMask | input | 8 | Per-slot mask, 1 = slot silent |
| cfgDiv | input | 8 | Bit-clock divider, half period = value+1 clocks |
| sampleData | input | 32 | Sample word, low bits used |
| sampleValid | input | 1 | Sample word available |
| sampleReady | output | 1 | Word taken this cycle |
| bclk | output | 1 | Serial bit clock |
| fsync | output | 1 | Frame sync |
| serData | output | 1 | Serial data |
| txActive | output | 1 | Transmitter running |

## Verification
The embedded assertions check on every cycle that the engine stops only at the last bit of a frame and that words are taken only while it runs. They also check that masked slots and the idle state keep the data line low, and that a pulse-style sync never lasts two bits. The exact placement of each sync edge relative to the data, the bit order, the bit period and the integral frame count can only be seen by the bench's sweeps. Those sweeps capture the serial stream at every receiving edge and compare it bit by bit with a frame computed arithmetically, covering each format, polarity, order, word length, slot count and mask pattern, plus runs with no sample data available.

// File: rtl/aftx_pkg.sv
package aftx_pkg;

  typedef enum logic [1:0] {
    FMT_STD       = 2'd0,
    FMT_LEFT      = 2'd1,
    FMT_DSP_EARLY = 2'd2,
    FMT_DSP_LATE  = 2'd3
  } fmt_e;

  // Strobes the control half hands to the datapath on each shift event
  typedef struct packed {
    logic shift;     // transmit edge of the bit clock
    logic load;      // capture the offered sample word
    logic clear;     // zero the held word
    logic run;       // engine active after this edge
    logic fsActive;  // frame sync asserted after this edge
  } strobe_t;

endpackage

// File: rtl/aftx_bclk_gen.sv
module aftx_bclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] cfgDiv,
  output logic             bclkRaw,
  output logic             fallStrobe
);

  logic [DIV_W-1:0] divQ;
  logic             levelQ;
  logic             halfDone;

  assign halfDone   = (divQ >= cfgDiv);
  assign fallStrobe = halfDone && levelQ;
  assign bclkRaw    = levelQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ   <= '0;
      levelQ <= 1'b0;
    end else if (halfDone) begin
      divQ   <= '0;
      levelQ <= ~levelQ;
    end else begin
      divQ <= divQ + 1'b1;
    end
  end

endmodule

// File: rtl/aftx_ctrl.sv
module aftx_ctrl
  import aftx_pkg::*;
#(
  parameter int WORD_MAX  = 32,
  parameter int SLOTS_MAX = 8,
  localparam int IDX_W  = $clog2(WORD_MAX),
  localparam int SLOT_W = $clog2(SLOTS_MAX),
  localparam int WLEN_W = $clog2(WORD_MAX + 1),
  localparam int CHAN_W = $clog2(SLOTS_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fallStrobe,
  input  logic                 txEnable,
  input  logic [1:0]           cfgFormat,
  input  logic [WLEN_W-1:0]    cfgWordLen,
  input  logic [CHAN_W-1:0]    cfgChans,
  input  logic [SLOTS_MAX-1:0] cfgSlotMask,
  input  logic                 cfgLsbFirst,
  input  logic                 sampleValid,
  output logic                 sampleReady,
  output strobe_t              ctl,
  output logic [IDX_W-1:0]     bitSel,
  output logic                 running,
  output logic [SLOT_W-1:0]    curSlot
);

  fmt_e fmt;
  assign fmt = fmt_e'(cfgFormat);

  logic              runQ, contQ;
  logic [IDX_W-1:0]  bitQ, nBit;
  logic [SLOT_W-1:0] slotQ, nSlot;
  logic              nRun, nCont;
  logic [WLEN_W-1:0] wlenM1;
  logic [CHAN_W-1:0] chansM1;
  logic              lastBitQ, atLast;
  logic              nLastBit, nAtLast;
  logic              firstSlot, earlyCue, fsN;
  logic              wordStart, slotOff;

  assign wlenM1   = cfgWordLen - 1'b1;
  assign chansM1  = cfgChans - 1'b1;
  assign lastBitQ = (WLEN_W'(bitQ) == wlenM1);
  assign atLast   = lastBitQ && (CHAN_W'(slotQ) == chansM1);

  // Next bit position; an idle engine enters the last position as a lead bit
  always_comb begin
    nBit  = bitQ;
    nSlot = slotQ;
    nRun  = runQ;
    if (!runQ) begin
      nBit  = wlenM1[IDX_W-1:0];
      nSlot = chansM1[SLOT_W-1:0];
      nRun  = txEnable;
    end else if (atLast) begin
      nBit  = '0;
      nSlot = '0;
      nRun  = contQ;
    end else if (lastBitQ) begin
      nBit  = '0;
      nSlot = slotQ + 1'b1;
    end else begin
      nBit = bitQ + 1'b1;
    end
  end

  assign nLastBit  = (WLEN_W'(nBit) == wlenM1);
  assign nAtLast   = nLastBit && (CHAN_W'(nSlot) == chansM1);
  assign nCont     = nAtLast ? txEnable : contQ;
  assign firstSlot = (nSlot == '0);
  assign earlyCue  = nAtLast && nCont;

  always_comb begin
    case (fmt)
      FMT_STD:       fsN = (firstSlot && !nLastBit) || earlyCue;
      FMT_LEFT:      fsN = firstSlot;
      FMT_DSP_EARLY: fsN = earlyCue;
      FMT_DSP_LATE:  fsN = firstSlot && (nBit == '0);
      default:       fsN = 1'b0;
    endcase
  end

  assign wordStart   = nRun && (nBit == '0);
  assign slotOff     = cfgSlotMask[nSlot];
  assign sampleReady = fallStrobe && wordStart && !slotOff && sampleValid;

  assign ctl.shift    = fallStrobe;
  assign ctl.load     = sampleReady;
  assign ctl.clear    = fallStrobe && !sampleReady && (!nRun || !runQ || (nBit == '0));
  assign ctl.run      = nRun;
  assign ctl.fsActive = nRun && fsN;

  assign bitSel  = cfgLsbFirst ? nBit : (wlenM1[IDX_W-1:0] - nBit);
  assign running = runQ;
  assign curSlot = slotQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      contQ <= 1'b0;
      bitQ  <= '0;
      slotQ <= '0;
    end else if (fallStrobe) begin
      runQ  <= nRun;
      contQ <= nCont;
      bitQ  <= nBit;
      slotQ <= nSlot;
    end
  end

  // R11: the engine only drops out of the running state from a frame's last bit
  p_stop_boundary_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(runQ) |-> $past(atLast));

  // R9: a word transfer happens only while a frame is being sent
  p_ready_active_r9: assert property (@(posedge clk) disable iff (!rstN)
    sampleReady |-> runQ);

endmodule

// File: rtl/aftx_datapath.sv
module aftx_datapath
  import aftx_pkg::*;
#(
  parameter int WORD_MAX = 32,
  localparam int IDX_W = $clog2(WORD_MAX)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             ctl,
  input  logic [IDX_W-1:0]    bitSel,
  input  logic [WORD_MAX-1:0] sampleData,
  input  logic [1:0]          cfgFormat,
  input  logic                cfgFsInv,
  output logic                serData,
  output logic                fsPin
);

  logic [WORD_MAX-1:0] wordQ;
  logic                dataQ;
  logic                fsActQ;
  logic                activeLow;
  logic                isPulse;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ  <= '0;
      dataQ  <= 1'b0;
      fsActQ <= 1'b0;
    end else if (ctl.shift) begin
      if (ctl.load)       wordQ <= sampleData;
      else if (ctl.clear) wordQ <= '0;
      if (!ctl.run)       dataQ <= 1'b0;
      else if (ctl.load)  dataQ <= sampleData[bitSel];
      else if (ctl.clear) dataQ <= 1'b0;
      else                dataQ <= wordQ[bitSel];
      fsActQ <= ctl.fsActive;
    end
  end

  assign activeLow = (cfgFormat == FMT_STD);
  assign isPulse   = (cfgFormat == FMT_DSP_EARLY) || (cfgFormat == FMT_DSP_LATE);
  assign serData   = dataQ;
  assign fsPin     = fsActQ ^ activeLow ^ cfgFsInv;

  // R3 and R4: a pulse-style sync never stays active into the following bit
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shift && fsActQ && isPulse) |=> !fsActQ);

endmodule

// File: rtl/audio_frame_tx.sv
module audio_frame_tx
  import aftx_pkg::*;
#(
  parameter int WORD_MAX  = 32,
  parameter int SLOTS_MAX = 8,
  parameter int DIV_W     = 8,
  localparam int IDX_W  = $clog2(WORD_MAX),
  localparam int SLOT_W = $clog2(SLOTS_MAX),
  localparam int WLEN_W = $clog2(WORD_MAX + 1),
  localparam int CHAN_W = $clog2(SLOTS_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 txEnable,
  input  logic [1:0]           cfgFormat,
  input  logic                 cfgBclkInv,
  input  logic                 cfgFsInv,
  input  logic                 cfgLsbFirst,
  input  logic [WLEN_W-1:0]    cfgWordLen,
  input  logic [CHAN_W-1:0]    cfgChans,
  input  logic [SLOTS_MAX-1:0] cfgSlotMask,
  input  logic [DIV_W-1:0]     cfgDiv,
  input  logic [WORD_MAX-1:0]  sampleData,
  input  logic                 sampleValid,
  output logic                 sampleReady,
  output logic                 bclk,
  output logic                 fsync,
  output logic                 serData,
  output logic                 txActive
);

  logic              bclkRaw, fallStrobe, running;
  strobe_t           ctl;
  logic [IDX_W-1:0]  bitSel;
  logic [SLOT_W-1:0] curSlot;

  aftx_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
    .clk        (clk),
    .rstN       (rstN),
    .cfgDiv     (cfgDiv),
    .bclkRaw    (bclkRaw),
    .fallStrobe (fallStrobe)
  );

  aftx_ctrl #(.WORD_MAX(WORD_MAX), .SLOTS_MAX(SLOTS_MAX)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .fallStrobe  (fallStrobe),
    .txEnable    (txEnable),
    .cfgFormat   (cfgFormat),
    .cfgWordLen  (cfgWordLen),
    .cfgChans    (cfgChans),
    .cfgSlotMask (cfgSlotMask),
    .cfgLsbFirst (cfgLsbFirst),
    .sampleValid (sampleValid),
    .sampleReady (sampleReady),
    .ctl         (ctl),
    .bitSel      (bitSel),
    .running     (running),
    .curSlot     (curSlot)
  );

  aftx_datapath #(.WORD_MAX(WORD_MAX)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .bitSel     (bitSel),
    .sampleData (sampleData),
    .cfgFormat  (cfgFormat),
    .cfgFsInv   (cfgFsInv),
    .serData    (serData),
    .fsPin      (fsync)
  );

  // The bit clock is gated low while idle; start and stop fall on its low phase
  assign bclk     = (running & bclkRaw) ^ cfgBclkInv;
  assign txActive = running;

  // R9: a silenced slot keeps the data line low
  p_masked_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (running && cfgSlotMask[curSlot]) |-> !serData);

  // R12: the data line is low whenever the engine is idle
  p_idle_low_r12: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !serData);

endmodule

// File: tb/audio_frame_tx_bench.sv
`timescale 1ns/1ps
module audio_frame_tx_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txEnable = 1'b0;
  logic [1:0]  cfgFormat = 2'd1;
  logic        cfgBclkInv = 1'b0;
  logic        cfgFsInv = 1'b0;
  logic        cfgLsbFirst = 1'b0;
  logic [5:0]  cfgWordLen = 6'd8;
  logic [3:0]  cfgChans = 4'd2;
  logic [7:0]  cfgSlotMask = 8'h00;
  logic [7:0]  cfgDiv = 8'd0;
  logic [31:0] sampleData = 32'h0;
  logic        sampleValid = 1'b0;
  logic        sampleReady, bclk, fsync, serData, txActive;

  int     errors = 0;
  int     total = 0;
  longint cyc = 0;

  logic   capFs [0:511];
  logic   capData [0:511];
  longint capCyc [0:511];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  audio_frame_tx u_audio_frame_tx (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .cfgFormat(cfgFormat),
    .cfgBclkInv(cfgBclkInv), .cfgFsInv(cfgFsInv), .cfgLsbFirst(cfgLsbFirst),
    .cfgWordLen(cfgWordLen), .cfgChans(cfgChans), .cfgSlotMask(cfgSlotMask),
    .cfgDiv(cfgDiv), .sampleData(sampleData), .sampleValid(sampleValid),
    .sampleReady(sampleReady), .bclk(bclk), .fsync(fsync), .serData(serData),
    .txActive(txActive)
  );

  function automatic logic [31:0] pat(input int j);
    return 32'h5A3C_96E1 ^ (32'(j) * 32'h0107_0B0D);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_check(input int fmt, input bit binv, input bit finv);
    chk(bclk == binv, "R12 R5 idle bclk", bclk, binv);
    chk(fsync == ((fmt == 0) ^ finv), "R12 R5 idle fsync", fsync, (fmt == 0) ^ finv);
    chk(serData == 1'b0, "R12 idle data", serData, 0);
    chk(txActive == 1'b0, "R12 idle active", txActive, 0);
  endtask

  task automatic run_case(input int fmt, input bit binv, input bit finv, input bit lsb,
                          input int w, input int n, input logic [7:0] mask,
                          input int div, input bit validOn, input int hold);
    int     nCap, feedIdx, xferCnt, cnt, lenL, frames, unm, wn;
    bit     pendAdv, done, prevNorm, normNow;
    logic [31:0] curWord;
    string  fsTag;
    @(negedge clk);
    cfgFormat = 2'(fmt); cfgBclkInv = binv; cfgFsInv = finv; cfgLsbFirst = lsb;
    cfgWordLen = 6'(w); cfgChans = 4'(n); cfgSlotMask = mask; cfgDiv = 8'(div);
    txEnable = 1'b0; sampleValid = validOn;
    feedIdx = 0; sampleData = pat(0); pendAdv = 0; xferCnt = 0; nCap = 0;
    repeat (4) @(negedge clk);
    idle_check(fmt, binv, finv);
    prevNorm = bclk ^ binv;
    txEnable = 1'b1;
    cnt = 0; done = 0;
    while (!done) begin
      @(negedge clk);
      cnt++;
      normNow = bclk ^ binv;
      if (txActive && normNow && !prevNorm && nCap < 512) begin
        capFs[nCap] = fsync; capData[nCap] = serData; capCyc[nCap] = cyc; nCap++;
      end
      prevNorm = normNow;
      if (pendAdv) begin feedIdx++; sampleData = pat(feedIdx); pendAdv = 0; end
      if (sampleValid && sampleReady) begin xferCnt++; pendAdv = 1; end
      if (cnt == hold) txEnable = 1'b0;
      if (cnt > hold && !txActive) done = 1;
      if (cnt > 30000) begin
        chk(0, "R11 stop timeout", cnt, hold);
        done = 1;
      end
    end
    lenL = w * n;
    frames = (nCap > 0) ? (nCap - 1) / lenL : 0;
    chk(nCap >= 1 + lenL && ((nCap - 1) % lenL) == 0, "R8 R11 bit count", nCap, 1 + frames * lenL);
    for (int k = 1; k < nCap; k++)
      chk(capCyc[k] - capCyc[k-1] == 2 * (div + 1), "R7 bit period",
          capCyc[k] - capCyc[k-1], 2 * (div + 1));
    fsTag = (fmt == 0) ? "R1 R5 fsync" : (fmt == 1) ? "R2 R5 fsync" :
            (fmt == 2) ? "R3 R5 fsync" : "R4 R5 fsync";
    wn = 0; curWord = 32'h0;
    for (int k = 0; k < nCap; k++) begin
      int  p, f, slot, b, idx;
      bit  cont, act, expFs, expD, masked;
      string dTag;
      if (k == 0) begin p = lenL - 1; f = -1; cont = 1; end
      else begin p = (k - 1) % lenL; f = (k - 1) / lenL; cont = (f < frames - 1); end
      slot = p / w; b = p % w;
      case (fmt)
        0: act = (p < w - 1) || (p == lenL - 1 && cont);
        1: act = (p < w);
        2: act = (p == lenL - 1 && cont);
        default: act = (p == 0);
      endcase
      expFs = (act ^ (fmt == 0)) ^ finv;
      chk(capFs[k] == expFs, fsTag, capFs[k], expFs);
      masked = mask[slot];
      if (k > 0 && b == 0) begin
        if (masked || !validOn) curWord = 32'h0;
        else begin curWord = pat(wn); wn++; end
      end
      idx = lsb ? b : (w - 1 - b);
      expD = (k == 0) ? 1'b0 : curWord[idx];
      dTag = (k == 0) ? "R8 lead data" : masked ? "R9 masked data" :
             !validOn ? "R10 underrun data" : "R6 data";
      chk(capData[k] == expD, dTag, capData[k], expD);
    end
    unm = 0;
    for (int s = 0; s < n; s++) if (!mask[s]) unm++;
    chk(xferCnt == (validOn ? frames * unm : 0), validOn ? "R9 transfers" : "R10 transfers",
        xferCnt, validOn ? frames * unm : 0);
    repeat (3) @(negedge clk);
    idle_check(fmt, binv, finv);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; total++;
    $display("FAIL R11 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(txActive == 0 && serData == 0 && bclk == 0 && fsync == 0, "R12 reset state",
        {txActive, serData, bclk, fsync}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(txActive == 0 && serData == 0 && bclk == 0 && fsync == 0, "R12 after reset",
        {txActive, serData, bclk, fsync}, 0);
    for (int sc = 0; sc < 32; sc++) begin
      int w, n, div, hold;
      logic [7:0] mask;
      w = (sc % 3 == 0) ? 8 : (sc % 3 == 1) ? 13 : 32;
      n = 1 + ((sc / 3) % 3);
      mask = (sc % 5 == 2) ? 8'h02 : (sc % 7 == 3) ? 8'h01 : 8'h00;
      div = (sc / 2) % 3;
      hold = w * n * 2 * (div + 1) * (1 + sc % 2) + 5;
      run_case(sc % 4, sc[2], sc[3], sc[4], w, n, mask, div, 1'b1, hold);
    end
    run_case(0, 1'b0, 1'b0, 1'b0, 8, 2, 8'h00, 0, 1'b0, 40);
    run_case(3, 1'b1, 1'b0, 1'b1, 16, 3, 8'h00, 1, 1'b0, 200);
    run_case(1, 1'b0, 1'b1, 1'b1, 8, 8, 8'h81, 0, 1'b1, 300);
    run_case(2, 1'b0, 1'b0, 1'b0, 8, 8, 8'h3C, 0, 1'b1, 150);
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

endmodule